// File: doc/BRIEF.md
# Banked CPU Register File

This block is the register storage of an 8-bit processor core. It keeps four general pairs (accumulator/flags, B/C, D/E, H/L), a shadow copy of each of those four, two index registers, the interrupt/refresh pair, the stack pointer and the program counter. Every pair is 16 bits and can be read or written as a word or as its high and low bytes. The decoder above it addresses pairs and bytes through small select codes. The block resolves those codes against a prefix latch. After an index prefix byte, any reference to the H/L pair or its halves goes to one of the two index registers until the instruction boundary.

Three further services sit beside the storage. An exchange unit swaps the accumulator pair with its shadow, swaps the three general pairs with their shadows, and swaps D/E with the true H/L pair. A step unit adds or subtracts one on a pair after a fixed wait. An address unit forms the effective address for indirect accesses. It adds a signed displacement only for an index base, and only after a fixed wait. The step and address units take their requests on valid/ready handshakes. A request is accepted on a clock edge where both are high. Each unit holds its ready low until its work completes. The address result is held stable with valid high until the consumer raises ready. The remaining pins are plain strobes.

Top module: `cpu_regfile`

## Requirements
- R1: Reset clears all pairs (shadows, index registers, IR, SP and PC included), the halt flag, both interrupt enables and the interrupt mode, and selects H/L as the active pair (idx_sel = 0). Both handshake readies are then high.
- R2: Pair select codes: 0 BC, 1 DE, 2 HL (subject to prefix), 3 SP, 4 AF, 5 IX, 6 IY, 7 PC, 8 IR, 9 true HL. Any other code reads 0 and ignores writes. Byte codes: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 F, 7 A. The first-named register of a pair is its high byte.
- R3: A prefix strobe with byte 0xDD makes IX the active pair (idx_sel = 1) and 0xFD makes IY active (idx_sel = 2). Any other byte is ignored. When prefixes follow one another, the last one is in effect.
- R4: An instruction-boundary strobe returns the active pair to H/L. If a prefix strobe arrives in the same cycle, the prefix takes effect instead.
- R5: While an index register is active, byte codes 4 and 5 address its high and low halves. With the byte "real" flag set, they address the true H and L.
- R6: Pair code 9, and the D/E-with-H/L exchange, always use the true H/L pair whatever prefix is active.
- R7: The accumulator exchange swaps AF with its shadow. The bank exchange swaps BC, DE and HL with their shadows. Exchanges take effect at the next clock edge.
- R8: An accepted address request whose base resolves to IX or IY yields base plus the sign-extended displacement, with ea_out_valid rising 5 cycles after the acceptance edge. Any other base yields the base unchanged, with ea_out_valid high right after the acceptance edge.
- R9: While ea_out_valid is high and ea_out_ready is low, ea_out_valid stays high and ea_addr holds. ea_in_ready is low from acceptance until the result is taken.
- R10: An accepted step request adds one (or subtracts one when step_dec is set) modulo 2^16 on the selected pair. The new value appears after the second edge following acceptance. The flags pair is untouched, and step_ready is low until the update lands.
- R11: Updates landing on the same edge apply in this order, later ones winning: exchanges, word write, byte write, step result.
- R12: A control write strobe loads the halt flag, both interrupt enables and the 2-bit interrupt mode. Without the strobe they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_valid | input | 1 | Prefix byte strobe |
| pfx_code | input | 8 | Prefix byte |
| insn_done | input | 1 | Instruction boundary strobe |
| rd_pair_sel | input | 4 | Word read select |
| rd_word | output | 16 | Word read data |
| rd_byte_sel | input | 3 | Byte read select |
| rd_byte_real | input | 1 | Byte read bypasses index override |
| rd_byte | output | 8 | Byte read data |
| wr_word_en | input | 1 | Word write strobe |
| wr_pair_sel | input | 4 | Word write select |
| wr_word_data | input | 16 | Word write data |
| wr_byte_en | input | 1 | Byte write strobe |
| wr_byte_sel | input | 3 | Byte write select |
| wr_byte_real | input | 1 | Byte write bypasses index override |
| wr_byte_data | input | 8 | Byte write data |
| xchg_af | input | 1 | Swap AF with shadow |
| xchg_dehl | input | 1 | Swap DE with true HL |
| xchg_banks | input | 1 | Swap BC, DE, HL with shadows |
| step_valid | input | 1 | Step request valid |
| step_ready | output | 1 | Step unit can accept |
| step_dec | input | 1 | 1 = decrement, 0 = increment |
| step_pair_sel | input | 4 | Pair to step |
| ea_in_valid | input | 1 | Address request valid |
| ea_in_ready | output | 1 | Address unit can accept |
| ea_base_sel | input | 4 | Base pair select |
| ea_disp | input | 8 | Signed displacement |
| ea_out_valid | output | 1 | Effective address valid |
| ea_out_ready | input | 1 | Consumer takes the address |
| ea_addr | output | 16 | Effective address |
| ctl_wr | input | 1 | Control flag write strobe |
| ctl_halt_d | input | 1 | Halt flag data |
| ctl_iff1_d | input | 1 | Interrupt enable 1 data |
| ctl_iff2_d | input | 1 | Interrupt enable 2 data |
| ctl_im_d | input | 2 | Interrupt mode data |
| halt | output | 1 | Halt flag |
| iff1 | output | 1 | Interrupt enable 1 |
| iff2 | output | 1 | Interrupt enable 2 |
| im | output | 2 | Interrupt mode |
| idx_sel | output | 2 | Active pair: 0 HL, 1 IX, 2 IY |

## Verification
The step result can land on the same edge as a decoder write or an exchange, and those two functions meet in that cycle. The bench accepts an increment on BC, then drives a byte write into B exactly two cycles later, on the completing edge. It expects the incremented word with the written byte discarded. It also fires the accumulator exchange and a word write to AF together. It expects the written word in AF and the former AF in the shadow, which a second exchange brings back.

// File: rtl/cpu_rf_pkg.sv
package cpu_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SLOT_N = 13;
  localparam int SLOT_W = $clog2(SLOT_N);
  localparam int PSEL_W = 4;
  localparam int BSEL_W = 3;

  // physical storage slots; shadows sit four above their live pair
  typedef enum logic [SLOT_W-1:0] {
    S_BC = 4'd0, S_DE = 4'd1, S_HL = 4'd2, S_AF = 4'd3,
    S_BC2 = 4'd4, S_DE2 = 4'd5, S_HL2 = 4'd6, S_AF2 = 4'd7,
    S_IX = 4'd8, S_IY = 4'd9, S_IR = 4'd10, S_SP = 4'd11, S_PC = 4'd12
  } slot_e;

  typedef enum logic [PSEL_W-1:0] {
    P_BC = 4'd0, P_DE = 4'd1, P_HL = 4'd2, P_SP = 4'd3, P_AF = 4'd4,
    P_IX = 4'd5, P_IY = 4'd6, P_PC = 4'd7, P_IR = 4'd8, P_HLR = 4'd9
  } pair_code_e;

  typedef enum logic [BSEL_W-1:0] {
    B_B = 3'd0, B_C = 3'd1, B_D = 3'd2, B_E = 3'd3,
    B_H = 3'd4, B_L = 3'd5, B_F = 3'd6, B_A = 3'd7
  } byte_code_e;

  typedef enum logic [1:0] {IDX_HL = 2'd0, IDX_IX = 2'd1, IDX_IY = 2'd2} idx_e;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] slot;
  } pair_ref_t;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic              hi;
  } byte_ref_t;

  function automatic logic [SLOT_W-1:0] hl_slot(input idx_e idx);
    case (idx)
      IDX_IX:  return S_IX;
      IDX_IY:  return S_IY;
      default: return S_HL;
    endcase
  endfunction

  function automatic pair_ref_t map_pair(input logic [PSEL_W-1:0] code, input idx_e idx);
    pair_ref_t r;
    r.ok   = 1'b1;
    r.slot = S_BC;
    case (code)
      P_BC:    r.slot = S_BC;
      P_DE:    r.slot = S_DE;
      P_HL:    r.slot = hl_slot(idx);
      P_SP:    r.slot = S_SP;
      P_AF:    r.slot = S_AF;
      P_IX:    r.slot = S_IX;
      P_IY:    r.slot = S_IY;
      P_PC:    r.slot = S_PC;
      P_IR:    r.slot = S_IR;
      P_HLR:   r.slot = S_HL;
      default: r.ok   = 1'b0;
    endcase
    return r;
  endfunction

  function automatic byte_ref_t map_byte(input logic [BSEL_W-1:0] code,
                                         input logic true_hl, input idx_e idx);
    byte_ref_t r;
    logic [SLOT_W-1:0] hs;
    hs = true_hl ? S_HL : hl_slot(idx);
    r.hi = ~code[0];
    case (code)
      B_B, B_C: r.slot = S_BC;
      B_D, B_E: r.slot = S_DE;
      B_H, B_L: r.slot = hs;
      default:  r.slot = S_AF;
    endcase
    if (code == B_A) r.hi = 1'b1;
    if (code == B_F) r.hi = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/rf_prefix_latch.sv
module rf_prefix_latch import cpu_rf_pkg::*; #(
  parameter logic [BYTE_W-1:0] PFX_IX = 8'hDD,
  parameter logic [BYTE_W-1:0] PFX_IY = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_valid,
  input  logic [BYTE_W-1:0] pfx_code,
  input  logic              insn_done,
  output idx_e              sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)                               sel <= IDX_HL;
    else if (pfx_valid && pfx_code == PFX_IX) sel <= IDX_IX;
    else if (pfx_valid && pfx_code == PFX_IY) sel <= IDX_IY;
    else if (insn_done)                       sel <= IDX_HL;
  end

  // R4
  revert_hl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !pfx_valid) |=> (sel == IDX_HL));

  // R3
  foreign_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_valid && pfx_code != PFX_IX && pfx_code != PFX_IY && !insn_done) |=> $stable(sel));
endmodule

// File: rtl/rf_storage.sv
module rf_storage import cpu_rf_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xchg_af,
  input  logic              xchg_banks,
  input  logic              xchg_dehl,
  input  logic              wr_word_en,
  input  logic [SLOT_W-1:0] wr_word_slot,
  input  logic [WORD_W-1:0] wr_word_data,
  input  logic              wr_byte_en,
  input  logic [SLOT_W-1:0] wr_byte_slot,
  input  logic              wr_byte_hi,
  input  logic [BYTE_W-1:0] wr_byte_data,
  input  logic              step_commit,
  input  logic [SLOT_W-1:0] step_slot,
  input  logic [WORD_W-1:0] step_data,
  output logic [WORD_W-1:0] q [SLOT_N]
);
  localparam int BANK_N = 3;
  localparam int SHADOW_OFS = 4;

  logic [WORD_W-1:0] sw [SLOT_N];

  // exchange network: accumulator swap, bank swap, then DE/true-HL swap
  always_comb begin
    logic [WORD_W-1:0] t;
    t = '0;
    for (int i = 0; i < SLOT_N; i++) sw[i] = q[i];
    if (xchg_af) begin
      sw[S_AF]  = q[S_AF2];
      sw[S_AF2] = q[S_AF];
    end
    if (xchg_banks) begin
      for (int i = 0; i < BANK_N; i++) begin
        t                 = sw[i];
        sw[i]             = sw[i + SHADOW_OFS];
        sw[i + SHADOW_OFS] = t;
      end
    end
    if (xchg_dehl) begin
      t        = sw[S_DE];
      sw[S_DE] = sw[S_HL];
      sw[S_HL] = t;
    end
  end

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    logic [WORD_W-1:0] nxt;
    always_comb begin
      nxt = sw[g];
      if (wr_word_en && wr_word_slot == SLOT_W'(g)) nxt = wr_word_data;
      if (wr_byte_en && wr_byte_slot == SLOT_W'(g)) begin
        if (wr_byte_hi) nxt[WORD_W-1:BYTE_W] = wr_byte_data;
        else            nxt[BYTE_W-1:0]      = wr_byte_data;
      end
      if (step_commit && step_slot == SLOT_W'(g)) nxt = step_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q[g] <= '0;
      else        q[g] <= nxt;
    end
  end

  // R7
  xchg_af_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_af && !xchg_banks && !wr_word_en && !wr_byte_en && !step_commit)
    |=> (q[S_AF] == $past(q[S_AF2]) && q[S_AF2] == $past(q[S_AF])));

  logic              chk_pend;
  logic [SLOT_W-1:0] chk_slot;
  logic [WORD_W-1:0] chk_data;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_pend <= 1'b0;
      chk_slot <= '0;
      chk_data <= '0;
    end else begin
      chk_pend <= step_commit;
      chk_slot <= step_slot;
      chk_data <= step_data;
    end
  end

  // R11
  step_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pend |-> (q[chk_slot] == chk_data));
endmodule

// File: rtl/rf_step_unit.sv
module rf_step_unit import cpu_rf_pkg::*; #(
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic              step_dec,
  input  logic              ref_ok,
  input  logic [SLOT_W-1:0] ref_slot,
  input  logic [WORD_W-1:0] cur_val,
  output logic              commit,
  output logic [SLOT_W-1:0] commit_slot,
  output logic [WORD_W-1:0] commit_data
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic             pend, dec_q, ok_q, last;
  logic [CNT_W-1:0] cnt;

  assign step_ready  = !pend;
  assign last        = pend && (cnt == CNT_W'(1));
  assign commit      = last && ok_q;
  assign commit_data = dec_q ? cur_val - WORD_W'(1) : cur_val + WORD_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= 1'b0;
      dec_q       <= 1'b0;
      ok_q        <= 1'b0;
      cnt         <= '0;
      commit_slot <= '0;
    end else if (step_valid && step_ready) begin
      pend        <= 1'b1;
      dec_q       <= step_dec;
      ok_q        <= ref_ok;
      cnt         <= CNT_W'(WAIT_CYC);
      commit_slot <= ref_slot;
    end else if (pend) begin
      if (last) pend <= 1'b0;
      else      cnt  <= cnt - CNT_W'(1);
    end
  end

  // R10
  step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && step_ready) |=> !step_ready);

  // R10
  step_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> step_ready);
endmodule

// File: rtl/rf_addr_gen.sv
module rf_addr_gen import cpu_rf_pkg::*; #(
  parameter int WAIT_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              base_ok,
  input  logic [SLOT_W-1:0] base_slot,
  input  logic [WORD_W-1:0] base_val,
  input  logic [BYTE_W-1:0] disp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] addr
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  typedef enum logic [1:0] {AG_IDLE, AG_WAIT, AG_OUT} ag_state_e;

  ag_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic              indexed, accept;
  logic [WORD_W-1:0] disp_x, base_eff;

  assign indexed   = base_ok && (base_slot == S_IX || base_slot == S_IY);
  assign in_ready  = (st == AG_IDLE);
  assign out_valid = (st == AG_OUT);
  assign accept    = in_valid && in_ready;
  assign disp_x    = {{(WORD_W-BYTE_W){disp[BYTE_W-1]}}, disp};
  assign base_eff  = base_ok ? base_val : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= AG_IDLE;
      cnt  <= '0;
      addr <= '0;
    end else begin
      case (st)
        AG_IDLE: if (accept) begin
          addr <= indexed ? base_eff + disp_x : base_eff;
          cnt  <= CNT_W'(WAIT_CYC);
          st   <= indexed ? AG_WAIT : AG_OUT;
        end
        AG_WAIT: begin
          if (cnt == CNT_W'(1)) st <= AG_OUT;
          else                  cnt <= cnt - CNT_W'(1);
        end
        default: if (out_ready) st <= AG_IDLE;
      endcase
    end
  end

  // R8
  ea_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !indexed) |=> out_valid);

  // R8
  ea_indexed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && indexed) |=> !out_valid);

  // R9
  ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(addr)));
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile import cpu_rf_pkg::*; #(
  parameter logic [BYTE_W-1:0] PFX_IX    = 8'hDD,
  parameter logic [BYTE_W-1:0] PFX_IY    = 8'hFD,
  parameter int                STEP_WAIT = 2,
  parameter int                DISP_WAIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_valid,
  input  logic [BYTE_W-1:0] pfx_code,
  input  logic              insn_done,
  input  logic [PSEL_W-1:0] rd_pair_sel,
  output logic [WORD_W-1:0] rd_word,
  input  logic [BSEL_W-1:0] rd_byte_sel,
  input  logic              rd_byte_real,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic              wr_word_en,
  input  logic [PSEL_W-1:0] wr_pair_sel,
  input  logic [WORD_W-1:0] wr_word_data,
  input  logic              wr_byte_en,
  input  logic [BSEL_W-1:0] wr_byte_sel,
  input  logic              wr_byte_real,
  input  logic [BYTE_W-1:0] wr_byte_data,
  input  logic              xchg_af,
  input  logic              xchg_dehl,
  input  logic              xchg_banks,
  input  logic              step_valid,
  output logic              step_ready,
  input  logic              step_dec,
  input  logic [PSEL_W-1:0] step_pair_sel,
  input  logic              ea_in_valid,
  output logic              ea_in_ready,
  input  logic [PSEL_W-1:0] ea_base_sel,
  input  logic [BYTE_W-1:0] ea_disp,
  output logic              ea_out_valid,
  input  logic              ea_out_ready,
  output logic [WORD_W-1:0] ea_addr,
  input  logic              ctl_wr,
  input  logic              ctl_halt_d,
  input  logic              ctl_iff1_d,
  input  logic              ctl_iff2_d,
  input  logic [1:0]        ctl_im_d,
  output logic              halt,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        im,
  output logic [1:0]        idx_sel
);
  idx_e              sel;
  logic [WORD_W-1:0] slot_q [SLOT_N];
  pair_ref_t         rd_ref, wr_ref, st_ref, ea_ref;
  byte_ref_t         rdb_ref, wrb_ref;
  logic              step_commit;
  logic [SLOT_W-1:0] step_slot;
  logic [WORD_W-1:0] step_data;
  logic [WORD_W-1:0] rdb_word;

  rf_prefix_latch #(.PFX_IX(PFX_IX), .PFX_IY(PFX_IY)) u_pfx (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_code(pfx_code),
    .insn_done(insn_done), .sel(sel)
  );

  assign idx_sel = sel;
  assign rd_ref  = map_pair(rd_pair_sel, sel);
  assign wr_ref  = map_pair(wr_pair_sel, sel);
  assign st_ref  = map_pair(step_pair_sel, sel);
  assign ea_ref  = map_pair(ea_base_sel, sel);
  assign rdb_ref = map_byte(rd_byte_sel, rd_byte_real, sel);
  assign wrb_ref = map_byte(wr_byte_sel, wr_byte_real, sel);

  assign rd_word  = rd_ref.ok ? slot_q[rd_ref.slot] : '0;
  assign rdb_word = slot_q[rdb_ref.slot];
  assign rd_byte  = rdb_ref.hi ? rdb_word[WORD_W-1:BYTE_W] : rdb_word[BYTE_W-1:0];

  rf_storage u_store (
    .clk(clk), .rst_n(rst_n),
    .xchg_af(xchg_af), .xchg_banks(xchg_banks), .xchg_dehl(xchg_dehl),
    .wr_word_en(wr_word_en && wr_ref.ok), .wr_word_slot(wr_ref.slot),
    .wr_word_data(wr_word_data),
    .wr_byte_en(wr_byte_en), .wr_byte_slot(wrb_ref.slot), .wr_byte_hi(wrb_ref.hi),
    .wr_byte_data(wr_byte_data),
    .step_commit(step_commit), .step_slot(step_slot), .step_data(step_data),
    .q(slot_q)
  );

  rf_step_unit #(.WAIT_CYC(STEP_WAIT)) u_step (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_ready(step_ready),
    .step_dec(step_dec), .ref_ok(st_ref.ok), .ref_slot(st_ref.slot),
    .cur_val(slot_q[step_slot]), .commit(step_commit), .commit_slot(step_slot),
    .commit_data(step_data)
  );

  rf_addr_gen #(.WAIT_CYC(DISP_WAIT)) u_ea (
    .clk(clk), .rst_n(rst_n), .in_valid(ea_in_valid), .in_ready(ea_in_ready),
    .base_ok(ea_ref.ok), .base_slot(ea_ref.slot),
    .base_val(slot_q[ea_ref.slot]), .disp(ea_disp),
    .out_valid(ea_out_valid), .out_ready(ea_out_ready), .addr(ea_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt <= 1'b0;
      iff1 <= 1'b0;
      iff2 <= 1'b0;
      im   <= 2'd0;
    end else if (ctl_wr) begin
      halt <= ctl_halt_d;
      iff1 <= ctl_iff1_d;
      iff2 <= ctl_iff2_d;
      im   <= ctl_im_d;
    end
  end

  // R12
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> ($stable(halt) && $stable(iff1) && $stable(iff2) && $stable(im)));

  // R6
  dehl_true_hl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_dehl && !xchg_banks && !wr_word_en && !wr_byte_en && !step_commit)
    |=> (slot_q[S_HL] == $past(slot_q[S_DE]) && $stable(slot_q[S_IX]) && $stable(slot_q[S_IY])));
endmodule

// File: tb/cpu_regfile_bench.sv
module cpu_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfx_valid = 0, insn_done = 0;
  logic [7:0] pfx_code = 0;
  logic [3:0] rd_pair_sel = 0, wr_pair_sel = 0, step_pair_sel = 0, ea_base_sel = 0;
  logic [15:0] rd_word, wr_word_data = 0, ea_addr;
  logic [2:0] rd_byte_sel = 0, wr_byte_sel = 0;
  logic rd_byte_real = 0, wr_byte_real = 0, wr_word_en = 0, wr_byte_en = 0;
  logic [7:0] rd_byte, wr_byte_data = 0, ea_disp = 0;
  logic xchg_af = 0, xchg_dehl = 0, xchg_banks = 0;
  logic step_valid = 0, step_ready, step_dec = 0;
  logic ea_in_valid = 0, ea_in_ready, ea_out_valid, ea_out_ready = 0;
  logic ctl_wr = 0, ctl_halt_d = 0, ctl_iff1_d = 0, ctl_iff2_d = 0;
  logic [1:0] ctl_im_d = 0, im, idx_sel;
  logic halt, iff1, iff2;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_regfile u_cpu_regfile (
    .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_code(pfx_code),
    .insn_done(insn_done), .rd_pair_sel(rd_pair_sel), .rd_word(rd_word),
    .rd_byte_sel(rd_byte_sel), .rd_byte_real(rd_byte_real), .rd_byte(rd_byte),
    .wr_word_en(wr_word_en), .wr_pair_sel(wr_pair_sel), .wr_word_data(wr_word_data),
    .wr_byte_en(wr_byte_en), .wr_byte_sel(wr_byte_sel), .wr_byte_real(wr_byte_real),
    .wr_byte_data(wr_byte_data), .xchg_af(xchg_af), .xchg_dehl(xchg_dehl),
    .xchg_banks(xchg_banks), .step_valid(step_valid), .step_ready(step_ready),
    .step_dec(step_dec), .step_pair_sel(step_pair_sel), .ea_in_valid(ea_in_valid),
    .ea_in_ready(ea_in_ready), .ea_base_sel(ea_base_sel), .ea_disp(ea_disp),
    .ea_out_valid(ea_out_valid), .ea_out_ready(ea_out_ready), .ea_addr(ea_addr),
    .ctl_wr(ctl_wr), .ctl_halt_d(ctl_halt_d), .ctl_iff1_d(ctl_iff1_d),
    .ctl_iff2_d(ctl_iff2_d), .ctl_im_d(ctl_im_d), .halt(halt), .iff1(iff1),
    .iff2(iff2), .im(im), .idx_sel(idx_sel)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pair(input string tag, input logic [3:0] code, input logic [15:0] exp);
    rd_pair_sel = code;
    #1;
    chk(tag, {16'h0, rd_word}, {16'h0, exp});
  endtask

  task automatic chk_byte(input string tag, input logic [2:0] code, input logic tru,
                          input logic [7:0] exp);
    rd_byte_sel  = code;
    rd_byte_real = tru;
    #1;
    chk(tag, {24'h0, rd_byte}, {24'h0, exp});
  endtask

  task automatic put_word(input logic [3:0] code, input logic [15:0] d);
    wr_word_en = 1; wr_pair_sel = code; wr_word_data = d;
    cyc();
    wr_word_en = 0;
  endtask

  task automatic put_byte(input logic [2:0] code, input logic tru, input logic [7:0] d);
    wr_byte_en = 1; wr_byte_sel = code; wr_byte_real = tru; wr_byte_data = d;
    cyc();
    wr_byte_en = 0; wr_byte_real = 0;
  endtask

  task automatic prefix(input logic [7:0] b);
    pfx_valid = 1; pfx_code = b;
    cyc();
    pfx_valid = 0;
  endtask

  task automatic boundary();
    insn_done = 1;
    cyc();
    insn_done = 0;
  endtask

  task automatic t_reset_state();
    for (int c = 0; c < 10; c++) chk_pair("R1 pair clear", 4'(c), 16'h0000);
    chk("R1 halt", {31'h0, halt}, 0);
    chk("R1 iff1/iff2", {30'h0, iff1, iff2}, 0);
    chk("R1 im", {30'h0, im}, 0);
    chk("R1 idx_sel", {30'h0, idx_sel}, 0);
    chk("R1 readies", {30'h0, step_ready, ea_in_ready}, 3);
  endtask

  task automatic t_byte_order();
    put_word(4'd4, 16'h12F5);
    chk_byte("R2 A is AF high", 3'd7, 0, 8'h12);
    chk_byte("R2 F is AF low", 3'd6, 0, 8'hF5);
    put_byte(3'd0, 0, 8'h9A);
    put_byte(3'd1, 0, 8'h3C);
    chk_pair("R2 BC from bytes", 4'd0, 16'h9A3C);
    put_word(4'd11, 16'hDEAD);
    chk_pair("R2 unused code reads zero", 4'd11, 16'h0000);
  endtask

  task automatic t_prefix();
    prefix(8'hDD);
    chk("R3 DD selects IX", {30'h0, idx_sel}, 1);
    put_word(4'd2, 16'hBEEF);
    chk_pair("R3 HL code lands in IX", 4'd5, 16'hBEEF);
    chk_pair("R3 true HL untouched", 4'd9, 16'h0000);
    prefix(8'h00);
    chk("R3 other byte ignored", {30'h0, idx_sel}, 1);
    prefix(8'hFD);
    chk("R3 FD selects IY", {30'h0, idx_sel}, 2);
    prefix(8'hDD);
    chk("R3 latest prefix wins", {30'h0, idx_sel}, 1);
  endtask

  task automatic t_boundary();
    boundary();
    chk("R4 boundary reverts", {30'h0, idx_sel}, 0);
    put_word(4'd2, 16'h1111);
    chk_pair("R4 HL code hits true HL", 4'd9, 16'h1111);
    chk_pair("R4 IX kept", 4'd5, 16'hBEEF);
    insn_done = 1; pfx_valid = 1; pfx_code = 8'hFD;
    cyc();
    insn_done = 0; pfx_valid = 0;
    chk("R4 prefix beats boundary", {30'h0, idx_sel}, 2);
    boundary();
  endtask

  task automatic t_byte_override();
    prefix(8'hFD);
    put_byte(3'd4, 0, 8'h77);
    chk_pair("R5 H maps to IY high", 4'd6, 16'h7700);
    put_byte(3'd5, 1, 8'h55);
    chk_pair("R5 true L written", 4'd9, 16'h1155);
    chk_byte("R5 L reads IY low", 3'd5, 0, 8'h00);
    chk_byte("R5 true L read", 3'd5, 1, 8'h55);
    boundary();
  endtask

  task automatic t_ex_dehl();
    put_word(4'd1, 16'h2222);
    prefix(8'hDD);
    xchg_dehl = 1;
    cyc();
    xchg_dehl = 0;
    chk_pair("R6 DE got true HL", 4'd1, 16'h1155);
    chk_pair("R6 true HL got DE", 4'd9, 16'h2222);
    chk_pair("R6 IX unaffected", 4'd5, 16'hBEEF);
    boundary();
  endtask

  task automatic xaf();
    xchg_af = 1; cyc(); xchg_af = 0;
  endtask

  task automatic xbanks();
    xchg_banks = 1; cyc(); xchg_banks = 0;
  endtask

  task automatic t_exchanges();
    xaf();
    chk_pair("R7 AF takes empty shadow", 4'd4, 16'h0000);
    put_word(4'd4, 16'h00AA);
    xaf();
    chk_pair("R7 AF restored", 4'd4, 16'h12F5);
    xbanks();
    chk_pair("R7 bank BC shadow", 4'd0, 16'h0000);
    chk_pair("R7 bank HL shadow", 4'd9, 16'h0000);
    put_word(4'd0, 16'h0101);
    xbanks();
    chk_pair("R7 BC back", 4'd0, 16'h9A3C);
    chk_pair("R7 DE back", 4'd1, 16'h1155);
    chk_pair("R7 HL back", 4'd9, 16'h2222);
    xbanks();
    chk_pair("R7 shadow BC kept", 4'd0, 16'h0101);
    xbanks();
  endtask

  task automatic t_addr();
    ea_in_valid = 1; ea_base_sel = 4'd0; ea_disp = 8'h10; ea_out_ready = 0;
    cyc();
    ea_in_valid = 0;
    chk("R8 direct valid next cycle", {31'h0, ea_out_valid}, 1);
    chk("R8 BC base unchanged", {16'h0, ea_addr}, {16'h0, 16'h9A3C});
    ea_out_ready = 1; cyc(); ea_out_ready = 0;
    chk("R9 taken, ready again", {30'h0, ea_out_valid, ea_in_ready}, 1);
    prefix(8'hDD);
    ea_in_valid = 1; ea_base_sel = 4'd2; ea_disp = 8'hFE;
    cyc();
    ea_in_valid = 0;
    chk("R8 indexed not yet valid", {31'h0, ea_out_valid}, 0);
    for (int k = 1; k < 5; k++) begin
      cyc();
      chk("R8 indexed wait", {31'h0, ea_out_valid}, 0);
    end
    cyc();
    chk("R8 indexed valid after 5", {31'h0, ea_out_valid}, 1);
    chk("R8 IX minus 2", {16'h0, ea_addr}, {16'h0, 16'hBEED});
    ea_in_valid = 1; ea_base_sel = 4'd9;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R9 held valid", {31'h0, ea_out_valid}, 1);
      chk("R9 held addr", {16'h0, ea_addr}, {16'h0, 16'hBEED});
      chk("R9 input blocked", {31'h0, ea_in_ready}, 0);
    end
    ea_in_valid = 0;
    ea_out_ready = 1; cyc(); ea_out_ready = 0;
    chk("R9 released", {31'h0, ea_out_valid}, 0);
    ea_in_valid = 1; ea_base_sel = 4'd9; ea_disp = 8'h7F;
    cyc();
    ea_in_valid = 0;
    chk("R8 true HL under prefix not indexed", {15'h0, ea_out_valid, ea_addr}, {15'h0, 1'b1, 16'h2222});
    ea_out_ready = 1; cyc(); ea_out_ready = 0;
    boundary();
  endtask

  task automatic t_step();
    put_word(4'd3, 16'hFFFF);
    step_valid = 1; step_pair_sel = 4'd3; step_dec = 0;
    cyc();
    step_valid = 0;
    chk("R10 busy after accept", {31'h0, step_ready}, 0);
    chk_pair("R10 SP not yet", 4'd3, 16'hFFFF);
    cyc();
    chk_pair("R10 SP after one wait", 4'd3, 16'hFFFF);
    cyc();
    chk_pair("R10 SP wraps to 0", 4'd3, 16'h0000);
    chk("R10 ready again", {31'h0, step_ready}, 1);
    chk_pair("R10 flags untouched", 4'd4, 16'h12F5);
    step_valid = 1; step_pair_sel = 4'd7; step_dec = 1;
    cyc(); step_valid = 0; cyc(); cyc();
    chk_pair("R10 PC decrement wraps", 4'd7, 16'hFFFF);
    prefix(8'hFD);
    step_valid = 1; step_pair_sel = 4'd2; step_dec = 0;
    cyc(); step_valid = 0; cyc(); cyc();
    boundary();
    chk_pair("R10 step on IY via prefix", 4'd6, 16'h7701);
    chk_pair("R10 true HL unchanged", 4'd9, 16'h2222);
  endtask

  task automatic t_collide();
    step_valid = 1; step_pair_sel = 4'd0; step_dec = 0;
    cyc(); step_valid = 0;
    cyc();
    put_byte(3'd0, 0, 8'h00);
    chk_pair("R11 step beats byte write", 4'd0, 16'h9A3D);
    xchg_af = 1; wr_word_en = 1; wr_pair_sel = 4'd4; wr_word_data = 16'h4242;
    cyc();
    xchg_af = 0; wr_word_en = 0;
    chk_pair("R11 write beats exchange", 4'd4, 16'h4242);
    xaf();
    chk_pair("R11 old AF went to shadow", 4'd4, 16'h12F5);
    wr_word_en = 1; wr_pair_sel = 4'd1; wr_word_data = 16'hAAAA;
    wr_byte_en = 1; wr_byte_sel = 3'd3; wr_byte_data = 8'h0F;
    cyc();
    wr_word_en = 0; wr_byte_en = 0;
    chk_pair("R11 byte over word", 4'd1, 16'hAA0F);
  endtask

  task automatic t_ctl();
    ctl_wr = 1; ctl_halt_d = 1; ctl_iff1_d = 1; ctl_iff2_d = 0; ctl_im_d = 2'd2;
    cyc();
    ctl_wr = 0; ctl_halt_d = 0; ctl_iff1_d = 0; ctl_iff2_d = 1; ctl_im_d = 2'd1;
    chk("R12 flags loaded", {27'h0, halt, iff1, iff2, im}, {27'h0, 5'b11010});
    cyc();
    chk("R12 flags hold", {27'h0, halt, iff1, iff2, im}, {27'h0, 5'b11010});
  endtask

  task automatic t_reset_again();
    prefix(8'hDD);
    rst_n = 0; cyc(); cyc(); rst_n = 1;
    chk("R1 reset idx", {30'h0, idx_sel}, 0);
    chk_pair("R1 reset IX", 4'd5, 16'h0000);
    chk_pair("R1 reset BC", 4'd0, 16'h0000);
    chk("R1 reset flags", {27'h0, halt, iff1, iff2, im}, 0);
    xaf();
    chk_pair("R1 shadow AF cleared", 4'd4, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all reqs) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc(); cyc();
    rst_n = 1;
    t_reset_state();
    t_byte_order();
    t_prefix();
    t_boundary();
    t_byte_override();
    t_ex_dehl();
    t_exchanges();
    t_addr();
    t_step();
    t_collide();
    t_ctl();
    t_reset_again();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule